// File: doc/BRIEF.md
# Power-Up Reset Sequencer

This block brings a handset's baseband supplies up in a fixed, timed order after a wake event and then releases the system reset. While powered off it watches four wake sources: a falling power-key line, a rising charger-detect flag, a rising battery-insert flag, and a high RTC alarm. When one of them fires, it waits a fixed wake delay. It then checks a battery-above-cutoff comparator flag. If the battery is good, it starts a startup watchdog and waits a settling delay. Next it enables the flash-supply regulator. A short time later it enables the group of core and I/O regulators together. Last, it holds the active-low system reset for a final delay and then releases it.

Throughout the reset phase the reference-oscillator regulator enable is held on, whatever the sleep request says. The watchdog is acknowledged by the rising edge of the system reset. If the watchdog runs out first, the block drops every enable and goes back to power-off. All delays are parameters counted in clock cycles. The analog comparators and regulators outside the block appear only as digital flags. The synchronous reset input acts as the power-off command.

Top module: `pwrup_seq`

## Requirements
- R1: In power-off, a wake event starts the sequence. A wake event is any of: pwr_key_n sampled 1 then 0, chg_det sampled 0 then 1, bat_ins sampled 0 then 1, or rtc_alarm sampled 1. For WAKE_DLY cycles after the event is sampled, every enable stays low and sys_rst_n stays low.
- R2: When the wake delay ends, a high bat_ok starts the settle stage, and wdog_run rises in the same cycle. A low bat_ok returns the block to power-off, with no enable ever raised and the block ready for a new wake event.
- R3: flash_en rises SETTLE_DLY cycles after the settle stage begins.
- R4: All NRAIL bits of rail_en rise together, FLASH_DLY cycles after flash_en. Bit 0 is the RF reference, bit 1 analog, bit 2 I/O and bit 3 core.
- R5: sys_rst_n and active rise HOLD_DLY cycles after rail_en. After that the flash and rail enables stay high.
- R6: osc_en is high from the start of the settle stage until reset is released, even while sleep_req is high. When running, osc_en equals the inverse of sleep_req. In power-off and the wake stage, osc_en is low.
- R7: If the watchdog runs out WDOG_DLY cycles after it starts, and reset has not been released, the block returns to power-off. All enables and wdog_run go low in that same cycle.
- R8: wdog_run falls in exactly the cycle in which sys_rst_n rises. If reset release and watchdog expiry fall on the same edge, the release wins.
- R9: Wake events are ignored outside power-off. A second event during the sequence does not shift any timing, and events while running change no output.
- R10: The enables never go out of order. rail_en is never nonzero without flash_en, and sys_rst_n is never high without all rail_en bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset / power-off command |
| pwr_key_n | input | 1 | Power key, low when pressed |
| chg_det | input | 1 | Charger-connected flag |
| bat_ins | input | 1 | Battery-inserted flag |
| rtc_alarm | input | 1 | RTC alarm pulse |
| bat_ok | input | 1 | Battery above cutoff |
| sleep_req | input | 1 | Sleep request for the oscillator regulator |
| flash_en | output | 1 | Flash-supply regulator enable |
| rail_en | output | NRAIL | Core/I/O regulator enables |
| osc_en | output | 1 | Reference-oscillator regulator enable |
| sys_rst_n | output | 1 | Active-low system reset |
| wdog_run | output | 1 | Startup watchdog running |
| active | output | 1 | Sequence complete, reset released |

## Verification
The two functions that can land on the same clock edge are the expiry of the startup watchdog and the release of the reset that acknowledges it. The bench provokes this with three copies of the block that share their inputs. In the first copy the watchdog timeout equals the settle, flash and hold delays added together, so expiry and release coincide. In the second copy the timeout is one cycle shorter. The third copy has a generous timeout. Judged against arithmetic cycle counts, the coincident copy must finish with reset released and the watchdog cleared. The copy one cycle shorter must drop every enable in the cycle just before release would have happened.

// File: rtl/pwrup_seq.sv
module pwrup_seq #(
  parameter int WAKE_DLY   = 655,
  parameter int SETTLE_DLY = 6554,
  parameter int FLASH_DLY  = 16,
  parameter int HOLD_DLY   = 655,
  parameter int WDOG_DLY   = 32768,
  parameter int NRAIL      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_key_n,
  input  logic             chg_det,
  input  logic             bat_ins,
  input  logic             rtc_alarm,
  input  logic             bat_ok,
  input  logic             sleep_req,
  output logic             flash_en,
  output logic [NRAIL-1:0] rail_en,
  output logic             osc_en,
  output logic             sys_rst_n,
  output logic             wdog_run,
  output logic             active
);

  localparam int MAX_AB = (WAKE_DLY > SETTLE_DLY) ? WAKE_DLY : SETTLE_DLY;
  localparam int MAX_CD = (FLASH_DLY > HOLD_DLY) ? FLASH_DLY : HOLD_DLY;
  localparam int MAXD   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CW     = $clog2(MAXD + 1);
  localparam int WW     = $clog2(WDOG_DLY + 1);

  typedef enum logic [2:0] {
    S_OFF, S_WAKE, S_SETTLE, S_FLASH, S_HOLD, S_ON
  } st_t;

  st_t         st;
  logic [CW-1:0] cnt;
  logic [WW-1:0] wd_cnt;
  logic        key_q, chg_q, bat_q;

  wire wake_evt = (key_q & ~pwr_key_n) | (~chg_q & chg_det) |
                  (~bat_q & bat_ins) | rtc_alarm;
  wire tick     = (cnt == '0);
  wire release_now = (st == S_HOLD) && tick;
  wire wd_exp   = wdog_run && (wd_cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_OFF;
      cnt      <= '0;
      wd_cnt   <= '0;
      wdog_run <= 1'b0;
      key_q    <= 1'b1;
      chg_q    <= 1'b0;
      bat_q    <= 1'b0;
    end else begin
      key_q <= pwr_key_n;
      chg_q <= chg_det;
      bat_q <= bat_ins;
      if (!tick) cnt <= cnt - 1'b1;
      if (wdog_run && wd_cnt != '0) wd_cnt <= wd_cnt - 1'b1;
      case (st)
        S_OFF:
          if (wake_evt) begin
            st  <= S_WAKE;
            cnt <= CW'(WAKE_DLY - 1);
          end
        S_WAKE:
          if (tick) begin
            if (bat_ok) begin
              st       <= S_SETTLE;
              cnt      <= CW'(SETTLE_DLY - 1);
              wdog_run <= 1'b1;
              wd_cnt   <= WW'(WDOG_DLY - 1);
            end else begin
              st <= S_OFF;
            end
          end
        S_SETTLE:
          if (tick) begin
            st  <= S_FLASH;
            cnt <= CW'(FLASH_DLY - 1);
          end
        S_FLASH:
          if (tick) begin
            st  <= S_HOLD;
            cnt <= CW'(HOLD_DLY - 1);
          end
        S_HOLD:
          if (tick) begin
            st       <= S_ON;
            wdog_run <= 1'b0;
          end
        default: ;
      endcase
      if (wd_exp && !release_now) begin
        st       <= S_OFF;
        wdog_run <= 1'b0;
      end
    end
  end

  wire in_reset_phase = (st == S_SETTLE) || (st == S_FLASH) || (st == S_HOLD);

  assign flash_en  = (st == S_FLASH) || (st == S_HOLD) || (st == S_ON);
  assign rail_en   = ((st == S_HOLD) || (st == S_ON)) ? {NRAIL{1'b1}} : '0;
  assign osc_en    = in_reset_phase || ((st == S_ON) && !sleep_req);
  assign sys_rst_n = (st == S_ON);
  assign active    = (st == S_ON);

  a_r1_quiet_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAKE) |-> (!osc_en && !flash_en && !sys_rst_n && rail_en == '0));

  a_r2_wdog_with_osc: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdog_run) |-> (osc_en && !flash_en));

  a_r3_flash_after_osc: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flash_en) |-> $past(osc_en));

  a_r4_rails_together: assert property (@(posedge clk) disable iff (!rst_n)
    (rail_en == '0) || (&rail_en));

  a_r6_osc_forced: assert property (@(posedge clk) disable iff (!rst_n)
    (wdog_run && !sys_rst_n) |-> osc_en);

  a_r7_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (wdog_run && wd_cnt == '0 && st != S_HOLD) |=> (!flash_en && !osc_en && !wdog_run));

  a_r8_ack_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_n) |-> (!wdog_run && $past(wdog_run)));

  a_r10_rail_needs_flash: assert property (@(posedge clk) disable iff (!rst_n)
    (rail_en != '0) |-> flash_en);

  a_r10_rst_needs_rails: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_n |-> (&rail_en));

endmodule

// File: tb/pwrup_seq_bench.sv
module pwrup_seq_bench;
  localparam int WK = 3, ST = 5, FL = 2, HD = 4, NR = 4;

  logic clk = 0;
  logic rst_n = 0;
  logic pwr_key_n = 1, chg_det = 0, bat_ins = 0, rtc_alarm = 0;
  logic bat_ok = 1, sleep_req = 1;

  logic          flash_en, osc_en, sys_rst_n, wdog_run, active;
  logic [NR-1:0] rail_en;
  logic          e_flash, e_osc, e_rst, e_wd, e_act;
  logic [NR-1:0] e_rail;
  logic          s_flash, s_osc, s_rst, s_wd, s_act;
  logic [NR-1:0] s_rail;

  int n_tests = 0, n_fail = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  pwrup_seq #(.WAKE_DLY(WK), .SETTLE_DLY(ST), .FLASH_DLY(FL), .HOLD_DLY(HD),
              .WDOG_DLY(40), .NRAIL(NR)) u_pwrup_seq (
    .clk, .rst_n, .pwr_key_n, .chg_det, .bat_ins, .rtc_alarm, .bat_ok, .sleep_req,
    .flash_en, .rail_en, .osc_en, .sys_rst_n, .wdog_run, .active);

  pwrup_seq #(.WAKE_DLY(WK), .SETTLE_DLY(ST), .FLASH_DLY(FL), .HOLD_DLY(HD),
              .WDOG_DLY(ST+FL+HD), .NRAIL(NR)) u_wd_eq (
    .clk, .rst_n, .pwr_key_n, .chg_det, .bat_ins, .rtc_alarm, .bat_ok, .sleep_req,
    .flash_en(e_flash), .rail_en(e_rail), .osc_en(e_osc), .sys_rst_n(e_rst),
    .wdog_run(e_wd), .active(e_act));

  pwrup_seq #(.WAKE_DLY(WK), .SETTLE_DLY(ST), .FLASH_DLY(FL), .HOLD_DLY(HD),
              .WDOG_DLY(ST+FL+HD-1), .NRAIL(NR)) u_wd_short (
    .clk, .rst_n, .pwr_key_n, .chg_det, .bat_ins, .rtc_alarm, .bat_ok, .sleep_req,
    .flash_en(s_flash), .rail_en(s_rail), .osc_en(s_osc), .sys_rst_n(s_rst),
    .wdog_run(s_wd), .active(s_act));

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; pwr_key_n = 1; chg_det = 0; bat_ins = 0; rtc_alarm = 0;
    bat_ok = 1; sleep_req = 1;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic fire(input int src);
    case (src)
      0: pwr_key_n = 0;
      1: chg_det = 1;
      2: bat_ins = 1;
      default: rtc_alarm = 1;
    endcase
  endtask

  int f_osc, f_flash, f_rail, f_rst, f_act, f_wd, f_wdoff, rail_at_first;
  int e_act_c, s_fl_seen, s_fl_drop, s_osc14, s_rail14, ign_extra;

  task automatic run(input int src, input int extra_evt);
    f_osc = 0; f_flash = 0; f_rail = 0; f_rst = 0; f_act = 0; f_wd = 0; f_wdoff = 0;
    rail_at_first = 0; e_act_c = 0; s_fl_seen = 0; s_fl_drop = 0;
    s_osc14 = -1; s_rail14 = -1;
    fire(src);
    for (int c = 1; c <= 24; c++) begin
      @(posedge clk);
      @(negedge clk);
      rtc_alarm = 0;
      if (extra_evt != 0 && c == 2) begin
        rtc_alarm = 1; pwr_key_n = 0;
      end
      if (f_osc == 0 && osc_en) f_osc = c;
      if (f_flash == 0 && flash_en) f_flash = c;
      if (f_rail == 0 && rail_en != 0) begin f_rail = c; rail_at_first = rail_en; end
      if (f_rst == 0 && sys_rst_n) f_rst = c;
      if (f_act == 0 && active) f_act = c;
      if (f_wd == 0 && wdog_run) f_wd = c;
      if (f_wd != 0 && f_wdoff == 0 && !wdog_run) f_wdoff = c;
      if (e_act_c == 0 && e_act) e_act_c = c;
      if (s_flash) s_fl_seen = 1;
      if (s_fl_seen != 0 && s_fl_drop == 0 && !s_flash) s_fl_drop = c;
      if (c == 14) begin s_osc14 = s_osc; s_rail14 = s_rail; end
    end
    rtc_alarm = 0;
  endtask

  initial begin
    do_reset();
    chk("R1 reset flash_en", flash_en, 0);
    chk("R1 reset rail_en", rail_en, 0);
    chk("R1 reset sys_rst_n", sys_rst_n, 0);
    chk("R6 reset osc_en", osc_en, 0);
    chk("R1 reset wdog_run", wdog_run, 0);

    for (int src = 0; src < 4; src++) begin
      do_reset();
      run(src, src == 1);
      chk($sformatf("R2 osc start src%0d", src), f_osc, 1 + WK);
      chk($sformatf("R2 wdog start src%0d", src), f_wd, 1 + WK);
      chk($sformatf("R3 flash src%0d", src), f_flash, 1 + WK + ST);
      chk($sformatf("R4 rails src%0d", src), f_rail, 1 + WK + ST + FL);
      chk($sformatf("R4 rails together src%0d", src), rail_at_first, (1 << NR) - 1);
      chk($sformatf("R5 release src%0d", src), f_rst, 1 + WK + ST + FL + HD);
      chk($sformatf("R5 active src%0d", src), f_act, 1 + WK + ST + FL + HD);
      chk($sformatf("R8 wdog ack src%0d", src), f_wdoff, 1 + WK + ST + FL + HD);
      chk($sformatf("R8 coincident release src%0d", src), e_act_c, 1 + WK + ST + FL + HD);
      chk($sformatf("R7 abort drop src%0d", src), s_fl_drop, 1 + WK + ST + FL + HD - 1);
      chk($sformatf("R7 abort osc src%0d", src), s_osc14, 0);
      chk($sformatf("R7 abort rails src%0d", src), s_rail14, 0);
      chk($sformatf("R7 abort inactive src%0d", src), s_act, 0);
      chk($sformatf("R6 osc follows sleep src%0d", src), osc_en, 0);
      sleep_req = 0;
      #1;
      chk($sformatf("R6 osc awake src%0d", src), osc_en, 1);
      sleep_req = 1;
    end

    pwr_key_n = 1;
    @(negedge clk);
    pwr_key_n = 0; rtc_alarm = 1; bat_ins = 1;
    repeat (20) begin
      @(negedge clk);
      rtc_alarm = 0;
    end
    chk("R9 active kept", active, 1);
    chk("R9 flash kept", flash_en, 1);
    chk("R9 rails kept", rail_en, (1 << NR) - 1);
    chk("R9 no watchdog restart", wdog_run, 0);

    do_reset();
    bat_ok = 0;
    run(0, 0);
    chk("R2 low battery osc", f_osc, 0);
    chk("R2 low battery flash", f_flash, 0);
    chk("R2 low battery wdog", f_wd, 0);
    bat_ok = 1;
    run(3, 0);
    chk("R2 rewake after low battery", f_flash, 1 + WK + ST);
    chk("R10 release after rewake", f_rst, 1 + WK + ST + FL + HD);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end
endmodule